// File: doc/BRIEF.md
# Strided Vector Operand Address Sequencer

This block turns one vector operand descriptor into a stream of byte addresses, one per element, which a load/store unit consumes. A descriptor is taken on a one-cycle `start` pulse while the sequencer is idle. It consists of:

- a 40-bit operand address, whose two low bits are not address bits but a stride-register selector (the operands are aligned, so those bits would otherwise be zero);
- an element width code;
- either a length field holding the element count minus one, or a 16-bit enable mask.

The three candidate stride values come in on their own ports. The block latches the whole descriptor, so its inputs may change freely once the sequence has begun.

A stride value n means that n whole element-sized areas are skipped between consecutive elements, so the address advances by (n+1) times the element size. In length mode, 1 to 256 consecutive elements are issued. In mask mode, exactly 16 positions are walked. The address advances at every position, but only positions whose mask bit is set are presented on the output stream. Each presented element carries its position index.

The output is a valid/ready stream. An element is transferred on a clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the address and index hold and valid stays asserted. `out_valid` never depends combinationally on `out_ready`. At most one element moves per clock. A one-cycle `done` pulse marks the end of the operand.

Top module: `vec_addr_seq`

## Requirements
- R1: After reset, `out_valid` and `done` are low and stay low until a `start` is given.
- R2: The first element is presented in the cycle after `start` is sampled. Its address is `cmd_addr` with bits [1:0] forced to zero, and its index is 0.
- R3: Width code 0 gives 4-byte elements and code 1 gives 8-byte elements. Codes 2 and 3 both give 16-byte elements.
- R4: Stride select `cmd_addr[1:0]` works as follows: 00 means no stride (n=0), 01 takes `stride_a`, 10 takes `stride_b` and 11 takes `stride_c`. The stride value is unsigned, and consecutive positions differ in address by (n+1)×element size.
- R5: With `mask_mode` low, `len_m1`+1 elements are issued, from 1 up to 256. They carry indices 0 to `len_m1` in increasing order.
- R6: With `mask_mode` high, `len_m1` is ignored and 16 positions are walked. Position p has address first + p×step. It is presented, with index p, only when `mask[p]` is 1. An all-zero mask presents nothing but still ends with `done`.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr` and `out_idx` keep their values into the next cycle.
- R8: `done` is high for exactly one cycle. That cycle is the one after the last element was accepted, or the one after the last mask position was passed. `out_valid` is low during it.
- R9: Address arithmetic is modulo 2^40: a sequence that runs past the top of the address space continues from zero.
- R10: A `start` pulse while a sequence is in progress is ignored, and the running sequence completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Descriptor strobe, honoured only when idle |
| cmd_addr | input | 40 | Operand address; bits [1:0] are the stride selector |
| width_code | input | 2 | Element width code |
| len_m1 | input | 8 | Element count minus one (length mode) |
| mask_mode | input | 1 | 1 selects the 16-position masked walk |
| mask | input | 16 | Position enables for mask mode, bit p for position p |
| stride_a | input | 32 | Stride value chosen by selector 01 |
| stride_b | input | 32 | Stride value chosen by selector 10 |
| stride_c | input | 32 | Stride value chosen by selector 11 |
| out_valid | output | 1 | An element address is presented |
| out_ready | input | 1 | Consumer accepts the presented element |
| out_addr | output | 40 | Element byte address |
| out_idx | output | 8 | Element position index |
| done | output | 1 | One-cycle end-of-operand pulse |

## Verification
The assertions rely on two assumptions about the consumer. It may hold `out_ready` low for any length of time, and it never sees a new descriptor start in the same cycle that the previous one ends, because `start` is only honoured from idle. With those assumptions, the indices within one sequence rise strictly and `done` never overlaps a valid element.

The stimulus sends every descriptor as a single `start` pulse. It holds the stride ports constant within a run. It drives `out_ready` either always high or in a repeating two-of-three pattern, so stalls fall both on the first element and in the middle of a sequence.

// File: rtl/vas_pkg.sv
package vas_pkg;
  typedef enum logic [1:0] {
    EW_SINGLE = 2'd0,
    EW_DOUBLE = 2'd1,
    EW_EXT    = 2'd2,
    EW_EXT_AL = 2'd3
  } ew_e;

  // log2 of the element size in bytes
  function automatic logic [2:0] ew_shift(input ew_e code);
    case (code)
      EW_SINGLE: ew_shift = 3'd2;
      EW_DOUBLE: ew_shift = 3'd3;
      default:   ew_shift = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/vas_step_calc.sv
module vas_step_calc #(
  parameter int ADDR_W = 40,
  parameter int SREG_W = 32
) (
  input  logic [1:0]        sel,
  input  logic [SREG_W-1:0] stride_a,
  input  logic [SREG_W-1:0] stride_b,
  input  logic [SREG_W-1:0] stride_c,
  input  logic [1:0]        width_code,
  output logic [ADDR_W-1:0] step
);
  import vas_pkg::*;

  logic [SREG_W-1:0] skip_n;
  logic [ADDR_W-1:0] span;

  always_comb begin
    case (sel)
      2'b01:   skip_n = stride_a;
      2'b10:   skip_n = stride_b;
      2'b11:   skip_n = stride_c;
      default: skip_n = '0;
    endcase
  end

  // (skipped elements + the element itself) times element size
  assign span = ADDR_W'(skip_n) + ADDR_W'(1);
  assign step = span << ew_shift(ew_e'(width_code));
endmodule

// File: rtl/vas_walker.sv
module vas_walker #(
  parameter int ADDR_W = 40,
  parameter int LEN_W  = 8,
  parameter int MASK_N = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [ADDR_W-1:0] step,
  input  logic [LEN_W-1:0]  last_pos,
  input  logic              mask_mode,
  input  logic [MASK_N-1:0] mask,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [LEN_W-1:0]  out_idx,
  output logic              done
);
  localparam int MSEL_W = $clog2(MASK_N);

  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] step_q;
  logic [LEN_W-1:0]  pos_q;
  logic [LEN_W-1:0]  last_q;
  logic              mmode_q;
  logic [MASK_N-1:0] mask_q;
  logic              pos_en;
  logic              advance;
  logic              at_last;

  assign pos_en    = !mmode_q || mask_q[pos_q[MSEL_W-1:0]];
  assign out_valid = busy_q && pos_en;
  assign advance   = busy_q && (!pos_en || out_ready);
  assign at_last   = (pos_q == last_q);
  assign out_addr  = addr_q;
  assign out_idx   = pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done    <= 1'b0;
      addr_q  <= '0;
      step_q  <= '0;
      pos_q   <= '0;
      last_q  <= '0;
      mmode_q <= 1'b0;
      mask_q  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          addr_q  <= first_addr;
          step_q  <= step;
          pos_q   <= '0;
          last_q  <= last_pos;
          mmode_q <= mask_mode;
          mask_q  <= mask;
        end
      end else if (advance) begin
        if (at_last) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end else begin
          pos_q  <= pos_q + LEN_W'(1);
          addr_q <= addr_q + step_q;
        end
      end
    end
  end
endmodule

// File: rtl/vec_addr_seq.sv
module vec_addr_seq #(
  parameter int ADDR_W = 40,
  parameter int SREG_W = 32,
  parameter int LEN_W  = 8,
  parameter int MASK_N = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [1:0]        width_code,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              mask_mode,
  input  logic [MASK_N-1:0] mask,
  input  logic [SREG_W-1:0] stride_a,
  input  logic [SREG_W-1:0] stride_b,
  input  logic [SREG_W-1:0] stride_c,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [LEN_W-1:0]  out_idx,
  output logic              done
);
  localparam logic [LEN_W-1:0] MASK_LAST = LEN_W'(MASK_N - 1);

  logic [ADDR_W-1:0] first_addr;
  logic [ADDR_W-1:0] step;
  logic [LEN_W-1:0]  last_pos;

  assign first_addr = {cmd_addr[ADDR_W-1:2], 2'b00};
  assign last_pos   = mask_mode ? MASK_LAST : len_m1;

  vas_step_calc #(.ADDR_W(ADDR_W), .SREG_W(SREG_W)) u_step (
    .sel        (cmd_addr[1:0]),
    .stride_a   (stride_a),
    .stride_b   (stride_b),
    .stride_c   (stride_c),
    .width_code (width_code),
    .step       (step)
  );

  vas_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MASK_N(MASK_N)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .first_addr (first_addr),
    .step       (step),
    .last_pos   (last_pos),
    .mask_mode  (mask_mode),
    .mask       (mask),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_addr   (out_addr),
    .out_idx    (out_idx),
    .done       (done)
  );
endmodule

// File: rtl/vas_chk.sv
module vas_chk #(
  parameter int ADDR_W = 40,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [LEN_W-1:0]  out_idx,
  input logic              done
);
  // R7
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_idx));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_addr[1:0] == 2'b00);

  // R5
  idx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid || (out_idx > $past(out_idx)));
endmodule

bind vec_addr_seq vas_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .out_idx   (out_idx),
  .done      (done)
);

// File: tb/vec_addr_seq_bench.sv
module vec_addr_seq_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, start, mask_mode, out_ready, out_valid, done;
  logic [39:0] cmd_addr, out_addr;
  logic [1:0]  width_code;
  logic [7:0]  len_m1, out_idx;
  logic [15:0] mask;
  logic [31:0] stride_a, stride_b, stride_c;

  vec_addr_seq u_vec_addr_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_addr(cmd_addr),
    .width_code(width_code), .len_m1(len_m1), .mask_mode(mask_mode),
    .mask(mask), .stride_a(stride_a), .stride_b(stride_b), .stride_c(stride_c),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_idx(out_idx), .done(done)
  );

  int checks = 0;
  int fails  = 0;

  typedef struct packed {
    logic [39:0] addr;
    logic [1:0]  wc;
    logic [7:0]  len;
    logic        msk;
    logic [15:0] mask;
    logic        stall;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{40'h00_0000_1000, 2'd0, 8'd3,   1'b0, 16'h0000, 1'b0},
    '{40'h00_0000_2001, 2'd1, 8'd4,   1'b0, 16'h0000, 1'b0},
    '{40'h00_0000_3002, 2'd2, 8'd2,   1'b0, 16'h0000, 1'b1},
    '{40'hFF_0000_0003, 2'd0, 8'd1,   1'b0, 16'h0000, 1'b0},
    '{40'hFF_FFFF_FF00, 2'd0, 8'd255, 1'b0, 16'h0000, 1'b1},
    '{40'h00_0000_5001, 2'd1, 8'd9,   1'b1, 16'hA5C3, 1'b1},
    '{40'h00_0000_6000, 2'd0, 8'd0,   1'b1, 16'h0000, 1'b0},
    '{40'h00_0000_7000, 2'd2, 8'd0,   1'b1, 16'hFFFF, 1'b0},
    '{40'h00_0000_8000, 2'd3, 8'd1,   1'b0, 16'h0000, 1'b0}
  };
  string tag_of [NV] = '{"R2", "R4", "R7", "R9", "R5", "R6", "R6", "R3", "R3"};

  localparam longint AMASK = 64'h0000_00FF_FFFF_FFFF;

  logic [39:0] ea [256];
  logic [7:0]  ei [256];
  int          en_total;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic build(input vec_t v);
    longint sz, n, stp, a;
    int cnt;
    sz = (v.wc == 2'd0) ? 4 : ((v.wc == 2'd1) ? 8 : 16);
    case (v.addr[1:0])
      2'b01:   n = longint'(stride_a);
      2'b10:   n = longint'(stride_b);
      2'b11:   n = longint'(stride_c);
      default: n = 0;
    endcase
    stp = ((n + 1) * sz) & AMASK;
    a   = longint'(v.addr) & AMASK & ~longint'(3);
    cnt = v.msk ? 16 : (int'(v.len) + 1);
    en_total = 0;
    for (int p = 0; p < cnt; p++) begin
      if (!v.msk || v.mask[p]) begin
        ea[en_total] = a[39:0];
        ei[en_total] = 8'(p);
        en_total++;
      end
      a = (a + stp) & AMASK;
    end
  endtask

  task automatic run(input vec_t v, input bit poke, input string tag);
    int k = 0;
    bit seen_done = 0;
    build(v);
    @(negedge clk);
    cmd_addr = v.addr; width_code = v.wc; len_m1 = v.len;
    mask_mode = v.msk; mask = v.mask; start = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      if (done) begin
        seen_done = 1;
        chk(!out_valid, "R8", "valid during done", out_valid, 0);
        break;
      end
      if (poke && cyc == 1) begin
        // R10: second descriptor while busy must be ignored
        start = 1'b1; cmd_addr = 40'h77_7777_7771; len_m1 = 8'd0; mask_mode = 1'b1;
      end else begin
        start = 1'b0;
      end
      out_ready = v.stall ? ((cyc % 3) != 0) : 1'b1;
      if (out_valid && out_ready) begin
        if (k < en_total) begin
          chk(out_addr == ea[k], tag, "address", out_addr, ea[k]);
          chk(out_idx == ei[k], tag, "index", out_idx, ei[k]);
        end else begin
          chk(0, tag, "extra element", k, en_total);
        end
        k++;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(seen_done, "R8", "done seen", seen_done, 1);
    chk(k == en_total, tag, "element count", k, en_total);
    @(negedge clk);
    chk(!done && !out_valid, "R8", "done single cycle", done, 0);
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; cmd_addr = '0; width_code = '0; len_m1 = '0;
    mask_mode = 1'b0; mask = '0; out_ready = 1'b1;
    stride_a = 32'd1; stride_b = 32'd3; stride_c = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: idle after reset
    chk(!out_valid, "R1", "valid after reset", out_valid, 0);
    chk(!done, "R1", "done after reset", done, 0);

    for (int i = 0; i < NV; i++) run(TBL[i], 1'b0, tag_of[i]);

    // R10: start pulse during a running sequence
    run('{40'h00_0000_9002, 2'd1, 8'd5, 1'b0, 16'h0000, 1'b1}, 1'b1, "R10");

    // R4: stride change between runs takes effect on the next descriptor
    stride_b = 32'd0;
    run('{40'h00_0000_A002, 2'd0, 8'd2, 1'b0, 16'h0000, 1'b0}, 1'b0, "R4");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule